// File: doc/BRIEF.md
# SPI command frame engine

This block is a single-lane SPI master that turns one request into one complete flash-style command frame. Each frame is built from up to four phases chosen per request: one opcode byte, an optional address of one to three bytes, an optional run of dummy bytes, and an optional data phase. The data phase either transmits or receives a requested number of bytes. The chip select is held low across all phases of the frame.

The request side latches the opcode, the address with its byte count, the dummy count, the direction and the data length in one handshake. Payload bytes leave through a valid/ready transmit stream and arrive through a valid/ready receive stream. Either stream can stall the serial clock between bytes without breaking the frame. The serial clock runs in mode 0 at the system clock divided by 2*DIV_HALF.

Top module: `spi_frame_engine`

## Requirements
- R1: While reset is applied and directly after it: cs_no=1, sclk_o=0, busy_o=0, done_o=0, req_ready_o=1, tx_ready_o=0, rx_valid_o=0.
- R2: A frame starts with the opcode byte, shifted MSB first. cs_no falls before the first sclk_o rise and stays low until after the last sclk_o fall. The frame has exactly 8*(1+address+dummy+data bytes) rising edges, and sclk_o is low whenever cs_no is high.
- R3: req_addr_cnt_i (0..3) selects how many of the low bytes of req_addr_i are sent, most significant of them first. A count of 0 sends no address byte.
- R4: req_dummy_cnt_i dummy bytes follow the address, each driven as 0xFF on mosi_o.
- R5: With req_rx_i=0, req_len_i bytes are taken from the transmit stream in order and shifted out. sclk_o stays low while the next byte has not been offered.
- R6: With req_rx_i=1, mosi_o carries 0xFF for req_len_i bytes, and miso_i is sampled on each sclk_o rise, MSB first. Each byte is offered on rx_data_o once its eighth bit is in and is held until it is accepted. The next byte does not start before that.
- R7: A request with req_len_i=0 has no data phase; the frame ends after the opcode, address and dummy bytes.
- R8: mode 0 timing: mosi_o never changes while sclk_o is high, and every high phase of sclk_o lasts DIV_HALF clock cycles.
- R9: busy_o is high from the cycle after a request is accepted until cs_no returns high. req_ready_o is its complement, and a request held valid while busy is ignored.
- R10: done_o is a single-cycle pulse in the first cycle in which cs_no is high again at the end of a frame.
- R11: A read-identification frame (opcode 0x9F, no address, no dummy, three receive bytes) has 32 clock rises and returns the three slave bytes in the order they were sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| req_valid_i | input | 1 | request offered |
| req_ready_o | output | 1 | request accepted when high with req_valid_i |
| req_opcode_i | input | 8 | opcode byte |
| req_addr_i | input | 8*ADDR_BYTES | address, low bytes used |
| req_addr_cnt_i | input | clog2(ADDR_BYTES+1) | address byte count |
| req_dummy_cnt_i | input | DUMMY_W | dummy byte count |
| req_rx_i | input | 1 | 1 receive data phase, 0 transmit |
| req_len_i | input | LEN_W | data phase length in bytes |
| tx_data_i | input | 8 | transmit stream byte |
| tx_valid_i | input | 1 | transmit byte offered |
| tx_ready_o | output | 1 | transmit byte taken |
| rx_data_o | output | 8 | received byte |
| rx_valid_o | output | 1 | received byte available |
| rx_ready_i | input | 1 | received byte consumed |
| sclk_o | output | 1 | serial clock |
| mosi_o | output | 1 | serial data out |
| miso_i | input | 1 | serial data in |
| cs_no | output | 1 | chip select, active low |
| busy_o | output | 1 | frame in progress |
| done_o | output | 1 | end-of-frame pulse |

## Verification
The assertions assume that a receive consumer drains the last received byte before the next frame is requested. They also assume that miso_i changes only between rising sclk_o edges, and that request fields stay in range. The stimulus meets these assumptions in the following ways. It waits for every expected receive byte before it finishes a frame. The slave model moves miso_i only on falling sclk_o edges and while the select is high. Random lengths, counts and stream stalls are drawn within the parameter ranges. Separate directed frames cover the empty data phase, read-identification, long receive back-pressure and a request held high while busy.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_OPC, PH_ADDR, PH_DUMMY, PH_TX, PH_RX, PH_HOLD
  } phase_e;

  localparam logic [7:0] FILL_BYTE = 8'hFF;
endpackage

// File: rtl/spi_clk_tick.sv
module spi_clk_tick #(
  parameter int unsigned DIV_HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  generate
    if (DIV_HALF <= 1) begin : g_every
      assign tick_o = run_i;
    end else begin : g_count
      localparam int unsigned CW = $clog2(DIV_HALF);
      localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else if (!run_i || cnt_q == LAST) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = run_i && (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_byte_i,
  input  logic         miso_i,
  output logic         active_o,
  output logic         byte_done_o,
  output logic         sclk_o,
  output logic         mosi_o,
  output logic [W-1:0] rx_byte_o
);
  localparam int unsigned BW = $clog2(W);
  localparam logic [BW-1:0] LAST_BIT = BW'(W - 1);

  logic          active_q, sclk_q;
  logic [BW-1:0] bit_q;
  logic [W-1:0]  tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      bit_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      sclk_q   <= 1'b0;
      bit_q    <= '0;
      tx_q     <= load_byte_i;
    end else if (active_q && tick_i) begin
      if (!sclk_q) begin
        sclk_q <= 1'b1;
        rx_q   <= {rx_q[W-2:0], miso_i};
      end else begin
        sclk_q <= 1'b0;
        if (bit_q == LAST_BIT) begin
          active_q <= 1'b0;
        end else begin
          bit_q <= bit_q + 1'b1;
          tx_q  <= {tx_q[W-2:0], 1'b0};
        end
      end
    end
  end

  assign active_o    = active_q;
  assign byte_done_o = active_q && tick_i && sclk_q && (bit_q == LAST_BIT);
  assign sclk_o      = sclk_q;
  assign mosi_o      = tx_q[W-1];
  assign rx_byte_o   = rx_q;
endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq
  import spi_frame_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 3,
  parameter int unsigned DUMMY_W    = 3,
  parameter int unsigned LEN_W      = 12
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_valid_i,
  output logic                          req_ready_o,
  input  logic [7:0]                    req_opcode_i,
  input  logic [8*ADDR_BYTES-1:0]       req_addr_i,
  input  logic [$clog2(ADDR_BYTES+1)-1:0] req_addr_cnt_i,
  input  logic [DUMMY_W-1:0]            req_dummy_cnt_i,
  input  logic                          req_rx_i,
  input  logic [LEN_W-1:0]              req_len_i,
  input  logic [7:0]                    tx_data_i,
  input  logic                          tx_valid_i,
  output logic                          tx_ready_o,
  output logic [7:0]                    rx_data_o,
  output logic                          rx_valid_o,
  input  logic                          rx_ready_i,
  input  logic                          tick_i,
  input  logic                          byte_done_i,
  input  logic [7:0]                    rx_byte_i,
  output logic                          load_o,
  output logic [7:0]                    load_byte_o,
  output logic                          run_o,
  output logic                          cs_no,
  output logic                          busy_o,
  output logic                          done_o
);
  localparam int unsigned ADDR_W = 8 * ADDR_BYTES;
  localparam int unsigned ACW    = $clog2(ADDR_BYTES + 1);
  localparam int unsigned MW     = (LEN_W > DUMMY_W) ? LEN_W : DUMMY_W;
  localparam int unsigned CNT_W  = (MW > ACW) ? MW : ACW;

  phase_e               phase_q, nxt_ph, data_ph, dum_ph, adr_ph;
  logic [CNT_W-1:0]     cnt_q, nxt_cnt;
  logic [7:0]           opc_q;
  logic [ADDR_W-1:0]    addr_q, addr_aligned;
  logic [ACW-1:0]       acnt_q;
  logic [DUMMY_W-1:0]   dummy_q;
  logic [LEN_W-1:0]     len_q;
  logic                 rx_q, inflight_q, cs_q, done_q, rx_valid_q, can_load;
  logic [7:0]           rx_data_q;

  // first address byte to the top of the shift window
  always_comb addr_aligned = req_addr_i << (8 * (ADDR_BYTES - 32'(req_addr_cnt_i)));

  always_comb begin
    data_ph = (len_q == '0) ? PH_HOLD : (rx_q ? PH_RX : PH_TX);
    dum_ph  = (dummy_q != '0) ? PH_DUMMY : data_ph;
    adr_ph  = (acnt_q != '0) ? PH_ADDR : dum_ph;
    case (phase_q)
      PH_OPC:   nxt_ph = adr_ph;
      PH_ADDR:  nxt_ph = dum_ph;
      PH_DUMMY: nxt_ph = data_ph;
      default:  nxt_ph = PH_HOLD;
    endcase
    case (nxt_ph)
      PH_ADDR:      nxt_cnt = CNT_W'(acnt_q);
      PH_DUMMY:     nxt_cnt = CNT_W'(dummy_q);
      PH_TX, PH_RX: nxt_cnt = CNT_W'(len_q);
      default:      nxt_cnt = '0;
    endcase
  end

  always_comb begin
    can_load    = 1'b0;
    load_byte_o = FILL_BYTE;
    case (phase_q)
      PH_OPC:   begin can_load = 1'b1; load_byte_o = opc_q; end
      PH_ADDR:  begin can_load = 1'b1; load_byte_o = addr_q[ADDR_W-1 -: 8]; end
      PH_DUMMY: can_load = 1'b1;
      PH_TX:    begin can_load = tx_valid_i; load_byte_o = tx_data_i; end
      PH_RX:    can_load = !rx_valid_q;
      default:  can_load = 1'b0;
    endcase
  end

  assign load_o      = can_load && !inflight_q;
  assign tx_ready_o  = (phase_q == PH_TX) && !inflight_q;
  assign run_o       = (phase_q == PH_SETUP) || (phase_q == PH_HOLD);
  assign req_ready_o = (phase_q == PH_IDLE);
  assign busy_o      = (phase_q != PH_IDLE);
  assign cs_no       = cs_q;
  assign done_o      = done_q;
  assign rx_valid_o  = rx_valid_q;
  assign rx_data_o   = rx_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      cnt_q      <= '0;
      opc_q      <= '0;
      addr_q     <= '0;
      acnt_q     <= '0;
      dummy_q    <= '0;
      len_q      <= '0;
      rx_q       <= 1'b0;
      inflight_q <= 1'b0;
      cs_q       <= 1'b1;
      done_q     <= 1'b0;
      rx_valid_q <= 1'b0;
      rx_data_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (rx_valid_q && rx_ready_i) rx_valid_q <= 1'b0;
      if (load_o) begin
        inflight_q <= 1'b1;
        if (phase_q == PH_ADDR) addr_q <= addr_q << 8;
      end
      case (phase_q)
        PH_IDLE: if (req_valid_i) begin
          opc_q   <= req_opcode_i;
          addr_q  <= addr_aligned;
          acnt_q  <= req_addr_cnt_i;
          dummy_q <= req_dummy_cnt_i;
          len_q   <= req_len_i;
          rx_q    <= req_rx_i;
          cs_q    <= 1'b0;
          phase_q <= PH_SETUP;
        end
        PH_SETUP: if (tick_i) begin
          phase_q <= PH_OPC;
          cnt_q   <= CNT_W'(1);
        end
        PH_HOLD: if (tick_i) begin
          cs_q    <= 1'b1;
          done_q  <= 1'b1;
          phase_q <= PH_IDLE;
        end
        default: if (byte_done_i) begin
          inflight_q <= 1'b0;
          if (phase_q == PH_RX) begin
            rx_data_q  <= rx_byte_i;
            rx_valid_q <= 1'b1;
          end
          if (cnt_q == CNT_W'(1)) begin
            phase_q <= nxt_ph;
            cnt_q   <= nxt_cnt;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine #(
  parameter int unsigned DIV_HALF   = 2,
  parameter int unsigned ADDR_BYTES = 3,
  parameter int unsigned DUMMY_W    = 3,
  parameter int unsigned LEN_W      = 12
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            req_valid_i,
  output logic                            req_ready_o,
  input  logic [7:0]                      req_opcode_i,
  input  logic [8*ADDR_BYTES-1:0]         req_addr_i,
  input  logic [$clog2(ADDR_BYTES+1)-1:0] req_addr_cnt_i,
  input  logic [DUMMY_W-1:0]              req_dummy_cnt_i,
  input  logic                            req_rx_i,
  input  logic [LEN_W-1:0]                req_len_i,
  input  logic [7:0]                      tx_data_i,
  input  logic                            tx_valid_i,
  output logic                            tx_ready_o,
  output logic [7:0]                      rx_data_o,
  output logic                            rx_valid_o,
  input  logic                            rx_ready_i,
  output logic                            sclk_o,
  output logic                            mosi_o,
  input  logic                            miso_i,
  output logic                            cs_no,
  output logic                            busy_o,
  output logic                            done_o
);
  logic tick, run_seq, active, byte_done, load;
  logic [7:0] load_byte, rx_byte;

  spi_clk_tick #(.DIV_HALF(DIV_HALF)) i_tick (
    .clk_i, .rst_ni,
    .run_i  (run_seq | active),
    .tick_o (tick)
  );

  spi_bit_shifter #(.W(8)) i_shift (
    .clk_i, .rst_ni,
    .tick_i      (tick),
    .load_i      (load),
    .load_byte_i (load_byte),
    .miso_i,
    .active_o    (active),
    .byte_done_o (byte_done),
    .sclk_o,
    .mosi_o,
    .rx_byte_o   (rx_byte)
  );

  spi_frame_seq #(
    .ADDR_BYTES(ADDR_BYTES), .DUMMY_W(DUMMY_W), .LEN_W(LEN_W)
  ) i_seq (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .req_opcode_i, .req_addr_i,
    .req_addr_cnt_i, .req_dummy_cnt_i, .req_rx_i, .req_len_i,
    .tx_data_i, .tx_valid_i, .tx_ready_o,
    .rx_data_o, .rx_valid_o, .rx_ready_i,
    .tick_i      (tick),
    .byte_done_i (byte_done),
    .rx_byte_i   (rx_byte),
    .load_o      (load),
    .load_byte_o (load_byte),
    .run_o       (run_seq),
    .cs_no, .busy_o, .done_o
  );
endmodule

// File: rtl/spi_frame_engine_chk.sv
module spi_frame_engine_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_ready_o,
  input logic       sclk_o,
  input logic       mosi_o,
  input logic       cs_no,
  input logic       busy_o,
  input logic       done_o,
  input logic       rx_valid_o,
  input logic       rx_ready_i,
  input logic [7:0] rx_data_o
);
  assert_sclk_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

  assert_mosi_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(mosi_o));

  assert_cs_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cs_no);

  assert_ready_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !req_ready_o);

  assert_done_edge_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_no && !busy_o && !$past(cs_no)));

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_rx_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o)));
endmodule

bind spi_frame_engine spi_frame_engine_chk i_chk (.*);

// File: tb/test_spi_frame_engine.sv
module test_spi_frame_engine;
  localparam int DIV = 3;
  localparam int DW  = 3;
  localparam int LW  = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid = 1'b0, req_rx = 1'b0, tx_valid = 1'b0, rx_ready = 1'b0;
  logic [7:0] req_opc = '0, tx_data = '0;
  logic [23:0] req_addr = '0;
  logic [1:0] req_acnt = '0;
  logic [DW-1:0] req_dcnt = '0;
  logic [LW-1:0] req_len = '0;
  logic req_ready_o, tx_ready_o, rx_valid_o, sclk_o, mosi_o, miso, cs_no, busy_o, done_o;
  logic [7:0] rx_data_o;

  int n_checks = 0, n_err = 0, frame_no = 0;
  int rise_cnt = 0, fall_cnt = 0, last_bits = 0, hi_cnt = 0, hi_bad = 0, hi_seen = 0;
  logic [7:0] mosi_cap [0:63];
  bit over;
  string rx_tag = "R6";

  always #5 clk = ~clk;

  spi_frame_engine #(.DIV_HALF(DIV), .ADDR_BYTES(3), .DUMMY_W(DW), .LEN_W(LW)) i_spi_frame_engine (
    .clk_i(clk), .rst_ni, .req_valid_i(req_valid), .req_ready_o,
    .req_opcode_i(req_opc), .req_addr_i(req_addr), .req_addr_cnt_i(req_acnt),
    .req_dummy_cnt_i(req_dcnt), .req_rx_i(req_rx), .req_len_i(req_len),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o,
    .rx_data_o, .rx_valid_o, .rx_ready_i(rx_ready),
    .sclk_o, .mosi_o, .miso_i(miso), .cs_no, .busy_o, .done_o);

  function automatic logic [7:0] slave_byte(int f, int i);
    return 8'((f * 29 + i * 53 + 7) & 255);
  endfunction
  function automatic logic [7:0] tx_byte(int f, int k);
    return 8'((f * 13 + k * 71 + 3) & 255);
  endfunction
  function automatic logic [7:0] addr_byte(logic [23:0] a, int ac, int i);
    return 8'(a >> (8 * (ac - 1 - i)));
  endfunction

  // slave model: capture on rise, shift out on fall
  always @(posedge sclk_o or posedge cs_no) begin
    if (cs_no) begin
      last_bits <= rise_cnt;
      rise_cnt  <= 0;
    end else begin
      if (rise_cnt < 512) mosi_cap[rise_cnt / 8][7 - rise_cnt % 8] <= mosi_o;
      rise_cnt <= rise_cnt + 1;
    end
  end
  always @(negedge sclk_o or posedge cs_no) begin
    if (cs_no) fall_cnt <= 0;
    else fall_cnt <= fall_cnt + 1;
  end
  always_comb begin
    logic [7:0] sb;
    sb = slave_byte(frame_no, fall_cnt / 8);
    miso = sb[7 - fall_cnt % 8];
  end

  always @(negedge clk) begin
    if (sclk_o) hi_cnt <= hi_cnt + 1;
    else if (hi_cnt != 0) begin
      if (hi_cnt != DIV) hi_bad <= hi_bad + 1;
      hi_seen <= hi_seen + 1;
      hi_cnt  <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input logic [7:0] opc, input logic [23:0] addr, input int ac,
                           input int dc, input bit rx, input int len, input int gap, input bit poke);
    int nb, k, j;
    nb = 1 + ac + dc + len;
    k = 0; j = 0;
    over = 0;
    @(negedge clk);
    req_opc = opc; req_addr = addr; req_acnt = 2'(ac); req_dcnt = DW'(dc);
    req_rx = rx; req_len = LW'(len); req_valid = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b1 && cs_no == 1'b0, "R9", "busy after accept", int'(busy_o), 1);
    if (poke) req_opc = 8'h55;
    else req_valid = 1'b0;
    fork
      begin : tx_feed
        bit hs;
        hs = 0;
        while (!over) begin
          @(negedge clk);
          if (hs) k++;
          if (!rx && k < len) begin
            tx_valid = ($urandom % 3 != 0);
            tx_data = tx_byte(frame_no, k);
          end else tx_valid = 1'b0;
          hs = tx_valid && tx_ready_o;
        end
        tx_valid = 1'b0;
      end
      begin : rx_take
        int w;
        w = 0;
        while (!over || rx_valid_o) begin
          @(negedge clk);
          if (rx_valid_o && w >= gap) rx_ready = 1'b1;
          else begin
            rx_ready = 1'b0;
            if (rx_valid_o) w++;
          end
          if (rx_valid_o && rx_ready) begin
            chk(rx_data_o == slave_byte(frame_no, 1 + ac + dc + j), rx_tag, "rx byte",
                int'(rx_data_o), int'(slave_byte(frame_no, 1 + ac + dc + j)));
            j++;
            w = 0;
          end
        end
        rx_ready = 1'b0;
      end
      begin : watch_end
        int cyc;
        cyc = 0;
        while (!done_o && cyc < 20000) begin
          @(negedge clk);
          cyc++;
          if (poke && cyc == 10)
            chk(req_ready_o == 1'b0, "R9", "ready while busy", int'(req_ready_o), 0);
          if (poke && cyc == 40) req_valid = 1'b0;
        end
        chk(done_o == 1'b1 && cs_no == 1'b1 && busy_o == 1'b0, "R10", "done with cs released",
            int'({done_o, cs_no, busy_o}), 3'b110);
        @(negedge clk);
        chk(done_o == 1'b0, "R10", "done single cycle", int'(done_o), 0);
        over = 1;
      end
    join
    chk(last_bits == 8 * nb, (len == 0) ? "R7" : "R2", "frame clock rises", last_bits, 8 * nb);
    for (int i = 0; i < nb && i < 64; i++) begin
      logic [7:0] e;
      string t;
      if (i == 0) begin e = opc; t = "R2"; end
      else if (i <= ac) begin e = addr_byte(addr, ac, i - 1); t = "R3"; end
      else if (i <= ac + dc) begin e = 8'hFF; t = "R4"; end
      else if (rx) begin e = 8'hFF; t = "R6"; end
      else begin e = tx_byte(frame_no, i - 1 - ac - dc); t = "R5"; end
      chk(mosi_cap[i] == e, t, "mosi byte", int'(mosi_cap[i]), int'(e));
    end
    if (rx) chk(j == len, rx_tag, "rx byte count", j, len);
    else chk(k == len, "R5", "tx byte count", k, len);
    frame_no++;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected frame end");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    chk(cs_no == 1'b1 && sclk_o == 1'b0 && busy_o == 1'b0 && done_o == 1'b0, "R1",
        "state in reset", int'({cs_no, sclk_o, busy_o, done_o}), 4'b1000);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(req_ready_o == 1'b1 && tx_ready_o == 1'b0 && rx_valid_o == 1'b0 && cs_no == 1'b1, "R1",
        "state after reset", int'({req_ready_o, tx_ready_o, rx_valid_o, cs_no}), 4'b1001);

    // R7: opcode only
    run_frame(8'h06, 24'h0, 0, 0, 1'b0, 0, 0, 1'b0);
    // R3: full address, one tx byte
    run_frame(8'h02, 24'hA1B2C3, 3, 0, 1'b0, 1, 0, 1'b0);
    // R11: read identification
    rx_tag = "R11";
    run_frame(8'h9F, 24'h0, 0, 0, 1'b1, 3, 0, 1'b0);
    chk(last_bits == 32, "R11", "id frame length", last_bits, 32);
    rx_tag = "R6";
    // R6: long receive back-pressure
    run_frame(8'h03, 24'h00_4D2E, 2, 1, 1'b1, 4, 80, 1'b0);
    // R9: request held during a frame is ignored
    run_frame(8'h32, 24'h12_3456, 3, 2, 1'b0, 4, 0, 1'b1);
    repeat (20) @(negedge clk);
    chk(busy_o == 1'b0 && cs_no == 1'b1, "R9", "no extra frame", int'(busy_o), 0);
    // R4 / R7: dummies and no data
    run_frame(8'hB7, 24'h00_0077, 1, 7, 1'b1, 0, 0, 1'b0);

    for (int n = 0; n < 24; n++) begin
      run_frame(8'($urandom), 24'($urandom), int'($urandom % 4), int'($urandom % 4),
                1'($urandom), int'($urandom % 13), int'($urandom % 5), 1'b0);
    end

    chk(hi_bad == 0 && hi_seen > 0, "R8", "sclk high length", hi_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule